// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block chooses, every clock cycle, at most one warp to issue. The choice is drawn only from a small active pool. The other resident warps sit in a pending pool. Only warps in the active pool may issue instructions. Only those warps may hold entries in the small upper register levels that sit close to the lanes. Warps move between the pools on explicit hints:

- A promote request lifts one pending warp into a free active slot.
- A demote hint that travels with an issued instruction sends that warp back to the pending pool once the instruction has gone.

The scheduler reports each move as an event. A promote event tells the register hierarchy to allocate upper-level space for the warp. A flush event tells it to write that warp's upper-level values back and release them.

Each warp is tracked by its own three-state machine:

- `WS_PENDING`: resident, but not allowed to issue.
- `WS_ACTIVE`: holds a slot and may issue.
- `WS_DRAIN`: demoted. It is being flushed for one cycle and still holds its slot.

The transitions are:

- `T_PROMOTE`: PENDING to ACTIVE, when the promote arbiter picks the warp.
- `T_DEMOTE`: ACTIVE to DRAIN, when the warp issues with a demote hint.
- `T_RETIRE`: DRAIN to PENDING, always one cycle after entering DRAIN.

Any other condition holds the state. Two round-robin pickers select among candidates. One chooses the issuing warp from the ready active warps. The other chooses the warp to promote from the pending warps. The issued instruction's per-thread execute mask is passed through with the selection.

Top module: `warp_sched2l`

## Requirements
- R1: After reset every warp is pending, so `issue_valid`, `promote_valid` and `flush_valid` are all 0.
- R2: `issue_valid` is 1 only when at least one active warp has its `warp_ready` bit set. The chosen `issue_warp` is always such a warp. Ready flags of pending or draining warps have no effect.
- R3: The issue search starts at the warp index one above the last issued warp and wraps modulo NUM_WARPS. After reset it starts at warp 0. The first ready active warp found is chosen, in the same cycle as the ready flags.
- R4: A promote request is accepted only if fewer than ACTIVE_SLOTS warps are active or draining and at least one warp is pending. If it is accepted, `promote_valid` is 1 in the next cycle and `promote_warp` names the warp. That warp may issue in that same cycle. A rejected request produces no event.
- R5: The promote search starts one index above the last promoted warp and wraps. After reset it starts at warp 0.
- R6: An issue with `demote_hint` at 1 is followed in the next cycle by `flush_valid`=1, with `flush_warp` naming the warp. In that cycle the warp cannot issue and still occupies its slot. From the cycle after that, the warp is pending and its slot is free.
- R7: `issue_tmask` equals bits [w*THREADS +: THREADS] of `warp_tmask`, where w is `issue_warp`. It is 0 when `issue_valid` is 0.
- R8: `demote_hint` has no effect in a cycle with no issue. No flush follows, and the active warps stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp flag: the next instruction can issue |
| warp_tmask | input | NUM_WARPS*THREADS | Per-warp thread execute masks, warp w at [w*THREADS +: THREADS] |
| promote_req | input | 1 | Hint asking for one pending warp to be promoted |
| demote_hint | input | 1 | Hint carried by this cycle's issued instruction: demote its warp |
| issue_valid | output | 1 | A warp is selected this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Selected warp index |
| issue_tmask | output | THREADS | Execute mask of the selected warp |
| promote_valid | output | 1 | Event: a warp entered the active pool |
| promote_warp | output | $clog2(NUM_WARPS) | Warp that was promoted |
| flush_valid | output | 1 | Event: flush the upper-level entries of a warp |
| flush_warp | output | $clog2(NUM_WARPS) | Warp being flushed |

## Verification
The assertions assume that `demote_hint` always refers to the instruction chosen in the same cycle. They also assume that `promote_req` may arrive in any state, including when the active pool is full. They place no demands on `warp_ready` for pending warps, because the design must ignore those flags. The directed stimulus changes inputs only at falling edges. It deliberately raises ready flags of pending warps, sends promote requests into a full pool and into a pool with a draining warp, and sends a demote hint when nothing issues. This keeps every situation the assertions cover reachable, without relying on any input constraint beyond reset being held for a few cycles.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    typedef enum logic [1:0] {
        WS_PENDING = 2'd0,
        WS_ACTIVE  = 2'd1,
        WS_DRAIN   = 2'd2
    } warp_state_e;

endpackage

// File: rtl/warp_state_fsm.sv
module warp_state_fsm
    import wsched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic promote_sel,
    input  logic demote_sel,
    output logic is_pending,
    output logic is_active,
    output logic is_drain
);

    warp_state_e state_q;
    warp_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_PENDING;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_PENDING: if (promote_sel) state_d = WS_ACTIVE;  // T_PROMOTE
            WS_ACTIVE:  if (demote_sel)  state_d = WS_DRAIN;   // T_DEMOTE
            WS_DRAIN:   state_d = WS_PENDING;                  // T_RETIRE
            default:    state_d = WS_PENDING;
        endcase
    end

    // Outputs
    always_comb begin
        is_pending = 1'b0;
        is_active  = 1'b0;
        is_drain   = 1'b0;
        unique case (state_q)
            WS_PENDING: is_pending = 1'b1;
            WS_ACTIVE:  is_active  = 1'b1;
            WS_DRAIN:   is_drain   = 1'b1;
            default:    is_pending = 1'b1;
        endcase
    end

    AST_PROMOTE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        promote_sel |-> state_q == WS_PENDING);  // R4
    AST_DEMOTE_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        demote_sel |-> state_q == WS_ACTIVE);  // R6
    AST_DRAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == WS_DRAIN |=> state_q == WS_PENDING);  // R6

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 32,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         grant_valid,
    output logic [W-1:0] grant_id
);

    always_comb begin
        grant_valid = 1'b0;
        grant_id    = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!grant_valid && req[idx]) begin
                grant_valid = 1'b1;
                grant_id    = W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_sched2l.sv
module warp_sched2l #(
    parameter int NUM_WARPS    = 32,
    parameter int THREADS      = 32,
    parameter int ACTIVE_SLOTS = 8,
    localparam int WID_W       = $clog2(NUM_WARPS),
    localparam int CNT_W       = $clog2(NUM_WARPS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WARPS-1:0]         warp_ready,
    input  logic [NUM_WARPS*THREADS-1:0] warp_tmask,
    input  logic                         promote_req,
    input  logic                         demote_hint,
    output logic                         issue_valid,
    output logic [WID_W-1:0]             issue_warp,
    output logic [THREADS-1:0]           issue_tmask,
    output logic                         promote_valid,
    output logic [WID_W-1:0]             promote_warp,
    output logic                         flush_valid,
    output logic [WID_W-1:0]             flush_warp
);

    localparam logic [CNT_W-1:0] SLOT_LIMIT = CNT_W'(ACTIVE_SLOTS);
    localparam logic [WID_W-1:0] LAST_IDX   = WID_W'(NUM_WARPS - 1);

    logic [NUM_WARPS-1:0] pend, act, drn, occ;
    logic [NUM_WARPS-1:0] promote_sel, demote_sel;
    logic [CNT_W-1:0]     occ_cnt;
    logic [WID_W-1:0]     last_issue_q, last_prom_q;
    logic                 prom_cand_valid, prom_take, demote_take;
    logic [WID_W-1:0]     prom_cand;

    // Per-warp state machines
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        warp_state_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .promote_sel(promote_sel[w]),
            .demote_sel (demote_sel[w]),
            .is_pending (pend[w]),
            .is_active  (act[w]),
            .is_drain   (drn[w])
        );
        assign promote_sel[w] = prom_take && (prom_cand == WID_W'(w));
        assign demote_sel[w]  = demote_take && (issue_warp == WID_W'(w));
    end

    assign occ = act | drn;

    always_comb begin
        occ_cnt = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            occ_cnt = occ_cnt + CNT_W'(occ[i]);
        end
    end

    // Issue selection among ready active warps
    rr_pick #(.N(NUM_WARPS), .W(WID_W)) u_issue_pick (
        .req        (act & warp_ready),
        .last       (last_issue_q),
        .grant_valid(issue_valid),
        .grant_id   (issue_warp)
    );

    // Promote selection among pending warps
    rr_pick #(.N(NUM_WARPS), .W(WID_W)) u_prom_pick (
        .req        (pend),
        .last       (last_prom_q),
        .grant_valid(prom_cand_valid),
        .grant_id   (prom_cand)
    );

    assign prom_take   = promote_req && prom_cand_valid && (occ_cnt < SLOT_LIMIT);
    assign demote_take = issue_valid && demote_hint;
    assign issue_tmask = issue_valid ? warp_tmask[issue_warp*THREADS +: THREADS] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_issue_q  <= LAST_IDX;
            last_prom_q   <= LAST_IDX;
            promote_valid <= 1'b0;
            promote_warp  <= '0;
            flush_valid   <= 1'b0;
            flush_warp    <= '0;
        end else begin
            if (issue_valid) last_issue_q <= issue_warp;
            if (prom_take)   last_prom_q  <= prom_cand;
            promote_valid <= prom_take;
            promote_warp  <= prom_cand;
            flush_valid   <= demote_take;
            flush_warp    <= issue_warp;
        end
    end

    AST_ACTIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(occ) <= ACTIVE_SLOTS);  // R4
    AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (act[issue_warp] && warp_ready[issue_warp]));  // R2
    AST_PROMOTED_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        promote_valid |-> (act[promote_warp] || drn[promote_warp]));  // R4
    AST_FLUSH_FOLLOWS_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && demote_hint) |=> (flush_valid && flush_warp == $past(issue_warp)));  // R6
    AST_FLUSH_WARP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> drn[flush_warp]);  // R6
    AST_NO_IDLE_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !flush_valid);  // R8

endmodule

// File: tb/test_warp_sched2l.sv
module test_warp_sched2l;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 32;
    localparam int TH = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NW-1:0]    warp_ready;
    logic [NW*TH-1:0] warp_tmask;
    logic             promote_req, demote_hint;
    logic             issue_valid, promote_valid, flush_valid;
    logic [4:0]       issue_warp, promote_warp, flush_warp;
    logic [TH-1:0]    issue_tmask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_sched2l i_warp_sched2l (
        .clk          (clk),
        .rst_n        (rst_n),
        .warp_ready   (warp_ready),
        .warp_tmask   (warp_tmask),
        .promote_req  (promote_req),
        .demote_hint  (demote_hint),
        .issue_valid  (issue_valid),
        .issue_warp   (issue_warp),
        .issue_tmask  (issue_tmask),
        .promote_valid(promote_valid),
        .promote_warp (promote_warp),
        .flush_valid  (flush_valid),
        .flush_warp   (flush_warp)
    );

    function automatic logic [31:0] exp_mask(int w);
        return 32'hA500_0000 | (32'(w) << 8) | 32'(w);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Advance one clock; returns just after the following falling edge
    task automatic cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        warp_ready = '1;
        #1;
        check("R1 issue_valid", 32'(issue_valid), 0);
        check("R1 promote_valid", 32'(promote_valid), 0);
        check("R1 flush_valid", 32'(flush_valid), 0);
        warp_ready = '0;
    endtask

    task automatic t_promote_fill();
        promote_req = 1'b1;
        for (int k = 0; k < 8; k++) begin
            cycle();
            check("R5 promote_valid", 32'(promote_valid), 1);
            check("R5 promote_warp", 32'(promote_warp), 32'(k));
        end
        cycle();
        check("R4 full pool rejects", 32'(promote_valid), 0);
        promote_req = 1'b0;
    endtask

    task automatic t_issue_rr();
        warp_ready = '1;
        for (int k = 0; k < 9; k++) begin
            #1;
            check("R3 issue_valid", 32'(issue_valid), 1);
            check("R3 issue order", 32'(issue_warp), 32'(k % 8));
            check("R7 mask", issue_tmask, exp_mask(k % 8));
            cycle();
        end
        warp_ready = '0;
        warp_ready[2]  = 1'b1;
        warp_ready[5]  = 1'b1;
        warp_ready[20] = 1'b1;
        #1; check("R3 skip to 2", 32'(issue_warp), 2); cycle();
        #1; check("R3 next 5", 32'(issue_warp), 5); check("R2 pending 20 not chosen", 32'(issue_valid), 1); cycle();
        #1; check("R3 wrap to 2", 32'(issue_warp), 2); cycle();
        warp_ready = '0;
        warp_ready[25] = 1'b1;
        #1;
        check("R2 only pending ready", 32'(issue_valid), 0);
        check("R7 idle mask", issue_tmask, 0);
    endtask

    task automatic t_demote();
        warp_ready = '0;
        warp_ready[3] = 1'b1;
        demote_hint = 1'b1;
        #1;
        check("R6 issue 3", 32'(issue_warp), 3);
        cycle();
        demote_hint = 1'b0;
        promote_req = 1'b1;
        #1;
        check("R6 flush_valid", 32'(flush_valid), 1);
        check("R6 flush_warp", 32'(flush_warp), 3);
        check("R6 no issue while draining", 32'(issue_valid), 0);
        cycle();
        check("R4 draining slot still held", 32'(promote_valid), 0);
        check("R6 single flush", 32'(flush_valid), 0);
        check("R6 warp 3 pending", 32'(issue_valid), 0);
        cycle();
        promote_req = 1'b0;
        check("R4 freed slot accepts", 32'(promote_valid), 1);
        check("R5 next after 7", 32'(promote_warp), 8);
    endtask

    task automatic t_demote_idle();
        warp_ready = '0;
        demote_hint = 1'b1;
        #1;
        check("R8 no issue", 32'(issue_valid), 0);
        cycle();
        demote_hint = 1'b0;
        check("R8 no flush", 32'(flush_valid), 0);
        warp_ready[8] = 1'b1;
        #1;
        check("R8 warp 8 still active", 32'(issue_valid), 1);
        check("R8 warp 8 issues", 32'(issue_warp), 8);
        check("R7 mask 8", issue_tmask, exp_mask(8));
    endtask

    task automatic t_promote_order();
        demote_hint = 1'b1;
        cycle();
        demote_hint = 1'b0;
        warp_ready = '0;
        cycle();
        promote_req = 1'b1;
        cycle();
        promote_req = 1'b0;
        check("R5 after 8 comes 9", 32'(promote_warp), 9);
        check("R5 promote_valid", 32'(promote_valid), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        warp_ready = '0;
        promote_req = 1'b0;
        demote_hint = 1'b0;
        for (int w = 0; w < NW; w++) warp_tmask[w*TH +: TH] = exp_mask(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_promote_fill();
        t_issue_rr();
        t_demote();
        t_demote_idle();
        t_promote_order();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule